// File: doc/BRIEF.md
# Posted Write Buffer with Address Match

This block is a write buffer placed in front of a memory port. A requester posts a write into a free slot and gets a completion on the next cycle, well before the data reaches memory. Each slot holds an address, a data line and a mask of the bytes that are valid. Every incoming read or write is first compared against all occupied slots. A read that matches takes its data from the slot. A write that matches is merged byte by byte into that slot and does not take a second one.

The requester manages its own credits. It starts with one credit per slot and spends one on each write. Credits come back on `credit_ret`, one for each slot freed by the memory port and one for each write merged into an existing slot. Slots that have been posted are offered to memory oldest first. Reads and later writes to other addresses are never held back by pending writes. A slot that holds only some of its bytes is written with a byte mask, so memory is never read to fill the gaps.

Top module: `wpq_cam`

## Requirements
- R1: After reset the buffer is empty: `occupancy` is 0, and `mem_valid`, `wr_cpl` and `rd_rsp_valid` are all 0.
- R2: A write that matches no slot takes a free slot. `wr_cpl` is high in the cycle after the write is accepted, and `occupancy` rises by one in that same cycle. `credit_ret` is 0 during a non-merging write when nothing is issued to memory.
- R3: A newly filled slot is offered to memory starting in the cycle after its completion. It is offered with its address, its data and its byte mask on `mem_addr`, `mem_data` and `mem_be`. Bit b of any byte mask covers data bits 8b+7 to 8b.
- R4: A write that matches an occupied slot, with all byte enables set, replaces that slot's data. `occupancy` does not change, and `credit_ret` counts 1 for the merge in the cycle the write is presented.
- R5: A write that matches an occupied slot, with only some byte enables set, changes only those bytes. The slot's byte mask becomes the OR of the old mask and the new enables.
- R6: A partial write that matches no slot stores only its enabled bytes, and the unwritten bytes read as zero. It is issued to memory with exactly those byte enables.
- R7: A read request gets a response one cycle later on `rd_rsp_valid`. If the read matches a slot whose byte mask is full, the response has `rd_rsp_hit`=1, the slot's data, `rd_rsp_be` all ones and `rd_rsp_mem`=0, meaning no memory read is needed.
- R8: A read that matches a partly filled slot returns `rd_rsp_hit`=1, the slot's bytes and that slot's byte mask, with `rd_rsp_mem`=1 so that the requester merges memory data into the missing bytes. A read that matches nothing returns `rd_rsp_hit`=0, `rd_rsp_be`=0 and `rd_rsp_mem`=1.
- R9: Among the posted slots, the one allocated earliest is offered to memory first, whatever its slot index.
- R10: A slot is freed only in a cycle where `mem_valid` and `mem_ready` are both high. `credit_ret` counts 1 for the freed slot in that cycle. While `mem_ready` is low, the offered address holds and `occupancy` does not fall.
- R11: A write whose address matches the slot being issued in the same cycle takes a new slot instead of merging. Only the new bytes are issued later.
- R12: A read is compared against the buffer as it stood before any write in the same cycle.
- R13: The buffer accepts DEPTH writes to distinct addresses with memory stalled, and `occupancy` reaches DEPTH. The slots then drain in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request; sent only while holding a credit |
| wr_addr | input | ADDR_W | Write line address |
| wr_data | input | 8*BYTES | Write data |
| wr_be | input | BYTES | Write byte enables |
| wr_cpl | output | 1 | Write posted completion, one cycle after acceptance |
| credit_ret | output | 2 | Credits returned this cycle (issue plus merge) |
| rd_valid | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read line address |
| rd_rsp_valid | output | 1 | Read response valid |
| rd_rsp_hit | output | 1 | Read matched a buffered write |
| rd_rsp_mem | output | 1 | Memory read still needed for missing bytes |
| rd_rsp_data | output | 8*BYTES | Buffered bytes of the matching slot |
| rd_rsp_be | output | BYTES | Which response bytes come from the buffer |
| mem_valid | output | 1 | A posted write is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered write |
| mem_addr | output | ADDR_W | Offered write address |
| mem_data | output | 8*BYTES | Offered write data |
| mem_be | output | BYTES | Offered write byte enables |
| occupancy | output | $clog2(DEPTH+1) | Number of occupied slots |

## Verification
Wrong match logic shows up in the first read response after the fault: a stale or mixed data line, or a byte mask that disagrees with the bytes written so far. A lost merge or a duplicate slot shows on `occupancy` one cycle after the write. It also shows on `credit_ret` in the cycle the write is presented. A corrupted age order or a wrongly freed slot shows on the memory port, as an address out of order or a data line that differs from what was posted. The bench compares every issued address, data line and mask with a model of the requests it sent.

// File: rtl/wpq_cam.sv
`timescale 1ns/1ps
module wpq_cam #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 16,
  parameter int BYTES  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_valid,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [8*BYTES-1:0]          wr_data,
  input  logic [BYTES-1:0]            wr_be,
  output logic                        wr_cpl,
  output logic [1:0]                  credit_ret,
  input  logic                        rd_valid,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic                        rd_rsp_valid,
  output logic                        rd_rsp_hit,
  output logic                        rd_rsp_mem,
  output logic [8*BYTES-1:0]          rd_rsp_data,
  output logic [BYTES-1:0]            rd_rsp_be,
  output logic                        mem_valid,
  input  logic                        mem_ready,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [8*BYTES-1:0]          mem_data,
  output logic [BYTES-1:0]            mem_be,
  output logic [$clog2(DEPTH+1)-1:0]  occupancy
);
  localparam int DATA_W = 8 * BYTES;
  localparam int OCC_W  = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  valid_q, posted_q;
  logic [ADDR_W-1:0] addr_q  [DEPTH];
  logic [DATA_W-1:0] data_q  [DEPTH];
  logic [BYTES-1:0]  be_q    [DEPTH];
  logic [DEPTH-1:0]  older_q [DEPTH];

  logic [DEPTH-1:0]  wr_hit_vec, wr_hit_eff, rd_hit_vec, elig, sel, free_vec, alloc_vec;
  logic [DATA_W-1:0] wr_mask, rd_data_mux;
  logic [BYTES-1:0]  rd_be_mux;
  logic              mem_fire, merge, have_slot;

  logic              cpl_q, rsp_valid_q, rsp_hit_q, rsp_mem_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [BYTES-1:0]  rsp_be_q;

  always_comb
    for (int b = 0; b < BYTES; b++) wr_mask[8*b +: 8] = {8{wr_be[b]}};

  always_comb
    for (int i = 0; i < DEPTH; i++) begin
      wr_hit_vec[i] = valid_q[i] && (addr_q[i] == wr_addr);
      rd_hit_vec[i] = valid_q[i] && (addr_q[i] == rd_addr);
    end

  assign elig = valid_q & posted_q;

  always_comb
    for (int i = 0; i < DEPTH; i++) begin
      sel[i] = elig[i];
      for (int j = 0; j < DEPTH; j++)
        if (elig[j] && older_q[j][i]) sel[i] = 1'b0;
    end

  always_comb begin
    mem_addr = '0;
    mem_data = '0;
    mem_be   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sel[i]) begin
        mem_addr = mem_addr | addr_q[i];
        mem_data = mem_data | data_q[i];
        mem_be   = mem_be   | be_q[i];
      end
  end

  assign mem_valid  = |elig;
  assign mem_fire   = mem_valid && mem_ready;
  assign free_vec   = mem_fire ? sel : '0;
  assign wr_hit_eff = wr_hit_vec & ~free_vec;
  assign merge      = wr_valid && (|wr_hit_eff);
  assign credit_ret = {1'b0, mem_fire} + {1'b0, merge};

  always_comb begin
    alloc_vec = '0;
    have_slot = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (!valid_q[i] && !have_slot) begin
        alloc_vec[i] = wr_valid && !merge;
        have_slot    = 1'b1;
      end
  end

  always_comb begin
    occupancy = '0;
    for (int i = 0; i < DEPTH; i++) occupancy = occupancy + OCC_W'(valid_q[i]);
  end

  always_comb begin
    rd_data_mux = '0;
    rd_be_mux   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_hit_vec[i]) begin
        rd_data_mux = rd_data_mux | data_q[i];
        rd_be_mux   = rd_be_mux   | be_q[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q     <= '0;
      posted_q    <= '0;
      cpl_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_mem_q   <= 1'b0;
      rsp_be_q    <= '0;
      rsp_data_q  <= '0;
    end else begin
      cpl_q       <= wr_valid;
      rsp_valid_q <= rd_valid;
      rsp_hit_q   <= |rd_hit_vec;
      rsp_mem_q   <= !((|rd_hit_vec) && (&rd_be_mux));
      rsp_be_q    <= rd_be_mux;
      rsp_data_q  <= rd_data_mux;
      for (int i = 0; i < DEPTH; i++) begin
        if (free_vec[i]) begin
          valid_q[i]  <= 1'b0;
          posted_q[i] <= 1'b0;
        end else if (alloc_vec[i]) begin
          valid_q[i]  <= 1'b1;
          posted_q[i] <= 1'b0;
        end else if (valid_q[i]) begin
          posted_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk)
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_vec[i]) begin
        addr_q[i] <= wr_addr;
        data_q[i] <= wr_data & wr_mask;
        be_q[i]   <= wr_be;
        for (int j = 0; j < DEPTH; j++) begin
          older_q[j][i] <= valid_q[j] && !free_vec[j];
          older_q[i][j] <= 1'b0;
        end
      end else if (merge && wr_hit_eff[i]) begin
        data_q[i] <= (data_q[i] & ~wr_mask) | (wr_data & wr_mask);
        be_q[i]   <= be_q[i] | wr_be;
      end
    end

  assign wr_cpl       = cpl_q;
  assign rd_rsp_valid = rsp_valid_q;
  assign rd_rsp_hit   = rsp_hit_q;
  assign rd_rsp_mem   = rsp_mem_q;
  assign rd_rsp_data  = rsp_data_q;
  assign rd_rsp_be    = rsp_be_q;
endmodule

module wpq_cam_chk #(
  parameter int DEPTH = 32,
  parameter int ADDR_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_valid,
  input logic                       wr_cpl,
  input logic                       rd_valid,
  input logic                       rd_rsp_valid,
  input logic                       mem_valid,
  input logic                       mem_ready,
  input logic [ADDR_W-1:0]          mem_addr,
  input logic [1:0]                 credit_ret,
  input logic [$clog2(DEPTH+1)-1:0] occupancy,
  input logic [DEPTH-1:0]           rd_hit_vec,
  input logic [DEPTH-1:0]           wr_hit_eff
);
  assert_unique_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_hit_vec));
  assert_cpl_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> wr_cpl);
  assert_rsp_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_rsp_valid);
  assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= ($clog2(DEPTH+1))'(DEPTH));
  assert_hold_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
  assert_credit_on_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |-> (credit_ret != 2'd0));
  assert_merge_keeps_occ_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (|wr_hit_eff) && !(mem_valid && mem_ready)) |=> occupancy == $past(occupancy));
endmodule

bind wpq_cam wpq_cam_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_cpl(wr_cpl),
  .rd_valid(rd_valid), .rd_rsp_valid(rd_rsp_valid), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .credit_ret(credit_ret),
  .occupancy(occupancy), .rd_hit_vec(rd_hit_vec), .wr_hit_eff(wr_hit_eff)
);

// File: tb/wpq_cam_tb_top.sv
`timescale 1ns/1ps
module wpq_cam_tb_top;
  localparam int DEPTH = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, rd_valid = 0, mem_ready = 0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_be = '0;
  logic wr_cpl, rd_rsp_valid, rd_rsp_hit, rd_rsp_mem, mem_valid;
  logic [1:0] credit_ret;
  logic [63:0] rd_rsp_data, mem_data;
  logic [7:0] rd_rsp_be, mem_be;
  logic [15:0] mem_addr;
  logic [5:0] occupancy;
  int total = 0, fails = 0;

  always #10 clk = ~clk;

  wpq_cam #(.DEPTH(DEPTH), .ADDR_W(16), .BYTES(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .wr_cpl(wr_cpl), .credit_ret(credit_ret),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_hit(rd_rsp_hit), .rd_rsp_mem(rd_rsp_mem), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_be(rd_rsp_be), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be), .occupancy(occupancy));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d, input logic [7:0] be,
                    output logic [1:0] cr);
    wr_valid = 1; wr_addr = a; wr_data = d; wr_be = be;
    #1 cr = credit_ret;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd(input logic [15:0] a);
    rd_valid = 1; rd_addr = a;
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic pop(input string req, input logic [15:0] a, input logic [63:0] d,
                     input logic [7:0] be);
    chk({req, " mem_valid"}, 64'(mem_valid), 64'd1);
    chk({req, " mem_addr"}, 64'(mem_addr), 64'(a));
    chk({req, " mem_data"}, mem_data, d);
    chk({req, " mem_be"}, 64'(mem_be), 64'(be));
    mem_ready = 1;
    #1 chk({req, " issue credit"}, 64'(credit_ret), 64'd1);
    @(negedge clk);
    mem_ready = 0;
  endtask

  task automatic t_reset;
    chk("R1 occupancy", 64'(occupancy), 0);
    chk("R1 mem_valid", 64'(mem_valid), 0);
    chk("R1 wr_cpl", 64'(wr_cpl), 0);
    chk("R1 rd_rsp_valid", 64'(rd_rsp_valid), 0);
  endtask

  task automatic t_write_miss;
    logic [1:0] cr;
    wr(16'h0100, 64'hA1A2A3A4A5A6A7A8, 8'hFF, cr);
    chk("R2 no credit", 64'(cr), 0);
    chk("R2 cpl", 64'(wr_cpl), 1);
    chk("R2 occupancy", 64'(occupancy), 1);
    chk("R3 not yet offered", 64'(mem_valid), 0);
    @(negedge clk);
    chk("R3 offered", 64'(mem_valid), 1);
    chk("R3 addr", 64'(mem_addr), 64'h0100);
    chk("R3 data", mem_data, 64'hA1A2A3A4A5A6A7A8);
    chk("R3 be", 64'(mem_be), 64'hFF);
  endtask

  task automatic t_reads;
    rd(16'h0100);
    chk("R7 rsp valid", 64'(rd_rsp_valid), 1);
    chk("R7 hit", 64'(rd_rsp_hit), 1);
    chk("R7 data", rd_rsp_data, 64'hA1A2A3A4A5A6A7A8);
    chk("R7 be", 64'(rd_rsp_be), 64'hFF);
    chk("R7 no mem", 64'(rd_rsp_mem), 0);
    rd(16'h0200);
    chk("R8 miss hit", 64'(rd_rsp_hit), 0);
    chk("R8 miss be", 64'(rd_rsp_be), 0);
    chk("R8 miss mem", 64'(rd_rsp_mem), 1);
  endtask

  task automatic t_full_hit;
    logic [1:0] cr;
    wr(16'h0100, 64'hB1B2B3B4B5B6B7B8, 8'hFF, cr);
    chk("R4 merge credit", 64'(cr), 1);
    chk("R4 occupancy", 64'(occupancy), 1);
    rd(16'h0100);
    chk("R4 new data", rd_rsp_data, 64'hB1B2B3B4B5B6B7B8);
  endtask

  task automatic t_partial;
    logic [1:0] cr;
    wr(16'h0300, 64'hC1C2C3C4C5C6C7C8, 8'h0F, cr);
    chk("R6 occupancy", 64'(occupancy), 2);
    rd(16'h0300);
    chk("R8 partial hit", 64'(rd_rsp_hit), 1);
    chk("R8 partial be", 64'(rd_rsp_be), 64'h0F);
    chk("R6 unwritten zero", rd_rsp_data, 64'h00000000C5C6C7C8);
    chk("R8 partial mem", 64'(rd_rsp_mem), 1);
    wr(16'h0300, 64'hD1D2D3D4D5D6D7D8, 8'hF0, cr);
    chk("R5 merge credit", 64'(cr), 1);
    rd(16'h0300);
    chk("R5 merged data", rd_rsp_data, 64'hD1D2D3D4C5C6C7C8);
    chk("R5 merged be", 64'(rd_rsp_be), 64'hFF);
    chk("R5 no mem", 64'(rd_rsp_mem), 0);
  endtask

  task automatic t_drain_basic;
    logic [1:0] cr;
    @(negedge clk);
    chk("R10 held addr", 64'(mem_addr), 64'h0100);
    chk("R10 no drop", 64'(occupancy), 2);
    pop("R9 first", 16'h0100, 64'hB1B2B3B4B5B6B7B8, 8'hFF);
    chk("R10 freed", 64'(occupancy), 1);
    pop("R9 second", 16'h0300, 64'hD1D2D3D4C5C6C7C8, 8'hFF);
    wr(16'h0400, 64'h1122334455667788, 8'h03, cr);
    @(negedge clk);
    pop("R6 masked issue", 16'h0400, 64'h0000000000007788, 8'h03);
    chk("R10 empty", 64'(occupancy), 0);
  endtask

  task automatic t_age;
    logic [1:0] cr;
    wr(16'h0010, 64'h10, 8'hFF, cr);
    wr(16'h0020, 64'h20, 8'hFF, cr);
    wr(16'h0030, 64'h30, 8'hFF, cr);
    @(negedge clk);
    pop("R9 age a", 16'h0010, 64'h10, 8'hFF);
    wr(16'h0040, 64'h40, 8'hFF, cr);
    @(negedge clk);
    pop("R9 age b", 16'h0020, 64'h20, 8'hFF);
    pop("R9 age c", 16'h0030, 64'h30, 8'hFF);
    pop("R9 age d", 16'h0040, 64'h40, 8'hFF);
  endtask

  task automatic t_collision;
    logic [1:0] cr;
    wr(16'h0500, 64'hE0E0E0E0E0E0E0E0, 8'hFF, cr);
    @(negedge clk);
    mem_ready = 1;
    wr(16'h0500, 64'hF1F2F3F4F5F6F7F8, 8'h0F, cr);
    mem_ready = 0;
    chk("R11 credit", 64'(cr), 1);
    chk("R11 occupancy", 64'(occupancy), 1);
    @(negedge clk);
    pop("R11 new entry", 16'h0500, 64'h00000000F5F6F7F8, 8'h0F);
  endtask

  task automatic t_same_cycle;
    logic [1:0] cr;
    rd_valid = 1; rd_addr = 16'h0600;
    wr(16'h0600, 64'h66, 8'hFF, cr);
    rd_valid = 0;
    chk("R12 old view", 64'(rd_rsp_hit), 0);
    rd(16'h0600);
    chk("R12 later hit", 64'(rd_rsp_hit), 1);
    pop("R12 drain", 16'h0600, 64'h66, 8'hFF);
  endtask

  task automatic t_fill;
    logic [1:0] cr;
    for (int k = 0; k < DEPTH; k++) wr(16'h1000 + 16'(k), 64'(k) + 64'h500, 8'hFF, cr);
    @(negedge clk);
    chk("R13 full", 64'(occupancy), DEPTH);
    for (int k = 0; k < DEPTH; k++)
      pop("R13 drain order", 16'h1000 + 16'(k), 64'(k) + 64'h500, 8'hFF);
    chk("R13 empty", 64'(occupancy), 0);
    chk("R13 idle", 64'(mem_valid), 0);
  endtask

  initial begin
    #(20 * 200000);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_miss();
    t_reads();
    t_full_hit();
    t_partial();
    t_drain_basic();
    t_age();
    t_collision();
    t_same_cycle();
    t_fill();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule